// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block is a stereo serial audio receiver and transmitter pair that runs as a slave to externally supplied bit and word-select clocks. Both directions share one framing setting. The framing can be I2S, left-justified or right-justified. Samples can be 16, 18, 20 or 24 bits long. A frame holds 32 or 64 bit clocks. The receiver collects the serial input into a left word and a right word. It presents both words together with a single-cycle valid strobe. The transmitter shifts parallel left and right words out on the serial output, using the same framing.

The serial clock, word select and data input are brought into the system clock domain through a two-stage synchroniser. The edges of the bit clock are then detected in that domain. Input data is sampled on bit-clock rising edges and the output is changed on falling edges. One position counter per slot serves all three framings. It turns the word-select history into a data window, which gives the position of the MSB, or of the LSB in right-justified framing. The framing, word length and frame size are static: change them only while reset is held.

Top module: `serial_audio_port`

## Requirements
- R1: Configuration encodings: `fmtSel` 0 selects I2S, 1 selects left-justified, 2 selects right-justified, and 3 behaves as left-justified. `wordLen` 0/1/2/3 selects 16/18/20/24 bits. `frame64` 1 selects 64 bit clocks per frame and 0 selects 32. With a 32-clock frame the word length is 16 bits whatever `wordLen` holds.
- R2: Serial input is sampled on bit-clock rising edges and `sdoOut` changes only in the system-clock cycle after a detected bit-clock falling edge. Each bit-clock half period must span at least four system clocks.
- R3: In I2S framing, word select low marks the left slot. Each word's MSB sits on the second bit clock after the word-select transition.
- R4: In left-justified framing, word select high marks the left slot. The MSB sits on the first bit clock after the transition.
- R5: In right-justified framing, word select high marks the left slot. The LSB sits on the last bit clock before the next transition.
- R6: Received words are left-aligned in 24 bits, and the bits below the word length read zero.
- R7: `rxValid` is high for exactly one system clock after the last bit of the right word is sampled. `rxLeft` and `rxRight` change only in that cycle, and they then carry the same frame's left and right words.
- R8: `txLeft` and `txRight` are both sampled at the falling edge that prepares the first position of the left slot. Changes to them after that edge first appear in the next frame. The top N bits of each word are sent MSB first.
- R9: `sdoOut` is zero on every bit-clock position outside the data window of a slot.
- R10: After reset, no word is captured, no strobe is raised and `sdoOut` stays zero until the first word-select transition has been seen.
- R11: While reset is held, `rxValid`, `rxLeft`, `rxRight` and `sdoOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bckIn | input | 1 | External bit clock |
| lrIn | input | 1 | External word-select clock |
| sdiIn | input | 1 | Serial data input |
| fmtSel | input | 2 | Framing select |
| wordLen | input | 2 | Sample length select |
| frame64 | input | 1 | 1 = 64 bit clocks per frame, 0 = 32 |
| txLeft | input | 24 | Left word to transmit, MSB-aligned |
| txRight | input | 24 | Right word to transmit, MSB-aligned |
| rxLeft | output | 24 | Received left word, MSB-aligned |
| rxRight | output | 24 | Received right word, MSB-aligned |
| rxValid | output | 1 | One-cycle strobe when a received pair is ready |
| sdoOut | output | 1 | Serial data output |

## Verification
A bit-clock edge passes through two synchroniser flops and then an edge-detect flop. Its result therefore appears on `sdoOut` or `rxValid` at the third system-clock edge after the input changes. The bench holds each bit-clock half period for six system clocks and compares `sdoOut` on the fifth edge after it drives a falling edge, so the serial output has settled before the next rising edge is driven. The received words and the count of strobes are read twenty cycles after the final bit of the last frame, well after the last possible strobe. The first frame after reset is never compared on the serial output, because I2S framing borrows its first bit position from the previous frame.

// File: rtl/sap_pkg.sv
package sap_pkg;
  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  // Strobes from control to datapath, one set per system clock.
  typedef struct packed {
    logic       capture;      // sample sdi this cycle
    logic       first;        // first bit of window
    logic       last;         // last bit of window
    logic       leftCh;       // capture belongs to left slot
    logic       drive;        // update sdo this cycle
    logic       load;         // latch tx words this cycle
    logic       txActive;     // upcoming position is inside window
    logic       txLeftSlot;   // upcoming position is in left slot
    logic [4:0] txIdx;        // offset inside window
    logic [4:0] shiftAmt;     // left-alignment shift of a received word
  } strobe_t;

  function automatic logic [5:0] wordBits(input logic [1:0] sel, input logic frame64);
    if (!frame64) return 6'd16;
    case (sel)
      2'd0:    return 6'd16;
      2'd1:    return 6'd18;
      2'd2:    return 6'd20;
      default: return 6'd24;
    endcase
  endfunction
endpackage

// File: rtl/sap_ctrl.sv
module sap_ctrl
  import sap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 24,
  parameter int POS_W       = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bckIn,
  input  logic      lrIn,
  input  logic      sdiIn,
  input  logic [1:0] fmtSel,
  input  logic [1:0] wordLen,
  input  logic      frame64,
  output strobe_t   stb,
  output logic      sdiBit,
  output logic      riseEdge,
  output logic      fallEdge
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [SYNC_STAGES-1:0] bckSy, lrSy, sdiSy;
  logic bckD;
  logic bckS, lrS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bckSy <= '0;
      lrSy  <= '0;
      sdiSy <= '0;
      bckD  <= 1'b0;
    end else begin
      bckSy <= {bckSy[SYNC_STAGES-2:0], bckIn};
      lrSy  <= {lrSy[SYNC_STAGES-2:0], lrIn};
      sdiSy <= {sdiSy[SYNC_STAGES-2:0], sdiIn};
      bckD  <= bckSy[SYNC_STAGES-1];
    end
  end

  assign bckS     = bckSy[SYNC_STAGES-1];
  assign lrS      = lrSy[SYNC_STAGES-1];
  assign sdiBit   = sdiSy[SYNC_STAGES-1];
  assign riseEdge = bckS & ~bckD;
  assign fallEdge = ~bckS & bckD;

  // Slot tracking, updated at each rising edge.
  logic [POS_W-1:0] rawIdx;
  logic lrPrev, primed, seen;

  logic [POS_W-1:0] slotLen, nBits, winStart, rawNext, effPos, offset;
  logic isI2s, lrChange, curLeft, effLeft, ok, inWin;

  always_comb begin
    isI2s    = (fmt_e'(fmtSel) == FMT_I2S);
    slotLen  = frame64 ? POS_W'(32) : POS_W'(16);
    nBits    = POS_W'(wordBits(wordLen, frame64));
    winStart = (fmt_e'(fmtSel) == FMT_RJ) ? slotLen - nBits : '0;
    lrChange = primed && (lrS != lrPrev);
    rawNext  = lrChange ? '0 : ((rawIdx == POS_MAX) ? rawIdx : rawIdx + 1'b1);
    curLeft  = isI2s ? ~lrS : lrS;
    if (isI2s && rawNext == '0) begin
      effPos  = slotLen - 1'b1;
      effLeft = ~curLeft;
    end else if (isI2s) begin
      effPos  = rawNext - 1'b1;
      effLeft = curLeft;
    end else begin
      effPos  = rawNext;
      effLeft = curLeft;
    end
    ok     = seen || (lrChange && !isI2s);
    offset = effPos - winStart;
    inWin  = (effPos >= winStart) && (offset < nBits);

    stb.capture    = riseEdge & ok & inWin;
    stb.first      = (offset == '0);
    stb.last       = (offset == nBits - 1'b1);
    stb.leftCh     = effLeft;
    stb.drive      = fallEdge;
    stb.load       = fallEdge & ok & effLeft & (effPos == '0);
    stb.txActive   = ok & inWin;
    stb.txLeftSlot = effLeft;
    stb.txIdx      = offset[4:0];
    stb.shiftAmt   = 5'(WORD_W - int'(nBits));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawIdx <= POS_MAX;
      lrPrev <= 1'b0;
      primed <= 1'b0;
      seen   <= 1'b0;
    end else if (riseEdge) begin
      primed <= 1'b1;
      lrPrev <= lrS;
      rawIdx <= rawNext;
      if (lrChange) seen <= 1'b1;
    end
  end
endmodule

// File: rtl/sap_datapath.sv
module sap_datapath
  import sap_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              sdiBit,
  input  logic [WORD_W-1:0] txLeft,
  input  logic [WORD_W-1:0] txRight,
  output logic [WORD_W-1:0] rxLeft,
  output logic [WORD_W-1:0] rxRight,
  output logic              rxValid,
  output logic              sdoOut
);
  logic [WORD_W-1:0] rxSh, holdLeft, newSh, aligned;
  logic [WORD_W-1:0] txL, txR, txWord;
  int txBit;

  always_comb begin
    newSh   = stb.first ? {{(WORD_W-1){1'b0}}, sdiBit} : {rxSh[WORD_W-2:0], sdiBit};
    aligned = newSh << stb.shiftAmt;
    if (stb.txLeftSlot) txWord = stb.load ? txLeft : txL;
    else                txWord = stb.load ? txRight : txR;
    txBit = WORD_W - 1 - int'(stb.txIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh     <= '0;
      holdLeft <= '0;
      rxLeft   <= '0;
      rxRight  <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (stb.capture) begin
        rxSh <= newSh;
        if (stb.last) begin
          if (stb.leftCh) holdLeft <= aligned;
          else begin
            rxLeft  <= holdLeft;
            rxRight <= aligned;
            rxValid <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txL    <= '0;
      txR    <= '0;
      sdoOut <= 1'b0;
    end else if (stb.drive) begin
      if (stb.load) begin
        txL <= txLeft;
        txR <= txRight;
      end
      sdoOut <= stb.txActive ? txWord[txBit] : 1'b0;
    end
  end
endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
  import sap_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bckIn,
  input  logic              lrIn,
  input  logic              sdiIn,
  input  logic [1:0]        fmtSel,
  input  logic [1:0]        wordLen,
  input  logic              frame64,
  input  logic [WORD_W-1:0] txLeft,
  input  logic [WORD_W-1:0] txRight,
  output logic [WORD_W-1:0] rxLeft,
  output logic [WORD_W-1:0] rxRight,
  output logic              rxValid,
  output logic              sdoOut
);
  strobe_t stb;
  logic sdiBit, bckRise, bckFall;

  sap_ctrl #(.SYNC_STAGES(SYNC_STAGES), .WORD_W(WORD_W), .POS_W(6)) u_ctrl (
    .clk(clk), .rstN(rstN), .bckIn(bckIn), .lrIn(lrIn), .sdiIn(sdiIn),
    .fmtSel(fmtSel), .wordLen(wordLen), .frame64(frame64),
    .stb(stb), .sdiBit(sdiBit), .riseEdge(bckRise), .fallEdge(bckFall)
  );

  sap_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiBit(sdiBit),
    .txLeft(txLeft), .txRight(txRight),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid), .sdoOut(sdoOut)
  );
endmodule

// File: rtl/sap_checker.sv
module sap_checker #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              bckRise,
  input logic              bckFall,
  input logic              rxValid,
  input logic              sdoOut,
  input logic [WORD_W-1:0] rxLeft,
  input logic [WORD_W-1:0] rxRight,
  input logic [1:0]        wordLen,
  input logic              frame64
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  a_r7_valid_after_rise: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(bckRise));

  a_r7_left_held: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxLeft) |-> rxValid);

  a_r7_right_held: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxRight) |-> rxValid);

  a_r2_sdo_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdoOut) |-> $past(bckFall));

  a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && (!frame64 || wordLen == 2'd0)) |-> (rxLeft[7:0] == 8'd0 && rxRight[7:0] == 8'd0));
endmodule

bind serial_audio_port sap_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .bckRise(bckRise), .bckFall(bckFall),
  .rxValid(rxValid), .sdoOut(sdoOut), .rxLeft(rxLeft), .rxRight(rxRight),
  .wordLen(wordLen), .frame64(frame64)
);

// File: tb/sim_serial_audio_port.sv
module sim_serial_audio_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, bckIn, lrIn, sdiIn, frame64, rxValid, sdoOut;
  logic [1:0] fmtSel, wordLen;
  logic [23:0] txLeft, txRight, rxLeft, rxRight;

  int checks = 0;
  int errors = 0;
  int rxCount = 0;

  serial_audio_port u0 (
    .clk(clk), .rstN(rstN), .bckIn(bckIn), .lrIn(lrIn), .sdiIn(sdiIn),
    .fmtSel(fmtSel), .wordLen(wordLen), .frame64(frame64),
    .txLeft(txLeft), .txRight(txRight),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid), .sdoOut(sdoOut)
  );

  always @(negedge clk) if (rxValid === 1'b1) rxCount++;

  // {fmt, wordLen, frame64, left, right}
  localparam logic [52:0] VECS [10] = '{
    {2'd0, 2'd3, 1'b1, 24'hA5C3E1, 24'h3C96F0},
    {2'd0, 2'd0, 1'b1, 24'h8F0F00, 24'h71E200},
    {2'd0, 2'd3, 1'b0, 24'hC35A00, 24'h5AC300},
    {2'd1, 2'd3, 1'b1, 24'hF0A501, 24'h0F5A81},
    {2'd1, 2'd1, 1'b1, 24'h9B7FC0, 24'h6480C0},
    {2'd1, 2'd0, 1'b0, 24'hE71800, 24'h18E700},
    {2'd2, 2'd3, 1'b1, 24'h812345, 24'hFEDCBB},
    {2'd2, 2'd2, 1'b1, 24'hB4D2F0, 24'h4B2D10},
    {2'd2, 2'd0, 1'b0, 24'hD00B00, 24'h2FF400},
    {2'd3, 2'd2, 1'b1, 24'hC0FFE0, 24'h13579B}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nbOf(input logic [1:0] wl, input logic f64);
    if (!f64) return 16;
    return (wl == 2'd0) ? 16 : (wl == 2'd1) ? 18 : (wl == 2'd2) ? 20 : 24;
  endfunction

  function automatic logic ljAt(input int f, input int nb, input int s,
                                input logic [23:0] l, input logic [23:0] r, input int p);
    int ch, k, start;
    logic [23:0] w;
    ch = p / s;
    k = p % s;
    w = ch ? r : l;
    start = (f == 2) ? s - nb : 0;
    if (k >= start && k < start + nb) return w[23 - (k - start)];
    return 1'b0;
  endfunction

  function automatic logic streamBit(input int f, input int nb, input int s,
                                     input logic [23:0] l, input logic [23:0] r, input int j);
    if (f == 0) return ljAt(f, nb, s, l, r, (j + 2 * s - 1) % (2 * s));
    return ljAt(f, nb, s, l, r, j);
  endfunction

  task automatic doReset(input logic [1:0] f, input logic [1:0] wl, input logic f64);
    rstN = 1'b0;
    fmtSel = f;
    wordLen = wl;
    frame64 = f64;
    bckIn = 1'b1;
    lrIn = (f == 2'd0) ? 1'b1 : 1'b0;
    sdiIn = 1'b0;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (8) @(posedge clk);
  endtask

  task automatic sendFrame(input int f, input int nb, input int s,
                           input logic [23:0] l, input logic [23:0] r,
                           input bit doChk, input bit chg, input logic [23:0] chgVal,
                           input string req);
    int mism = 0;
    for (int j = 0; j < 2 * s; j++) begin
      logic expBit, leftHalf;
      expBit = streamBit(f, nb, s, l, r, j);
      leftHalf = (j < s);
      @(posedge clk);
      #1;
      bckIn = 1'b0;
      lrIn = (f == 0) ? !leftHalf : leftHalf;
      sdiIn = expBit;
      if (chg && j == 4) txLeft = chgVal;
      repeat (5) @(posedge clk);
      #1;
      if (doChk && sdoOut !== expBit) mism++;
      @(posedge clk);
      #1 bckIn = 1'b1;
      repeat (5) @(posedge clk);
    end
    if (doChk) check(req, mism, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    txLeft = 24'hFFFFFF;
    txRight = 24'hFFFFFF;
    rstN = 1'b0;
    bckIn = 1'b1;
    lrIn = 1'b0;
    sdiIn = 1'b1;
    fmtSel = 2'd1;
    wordLen = 2'd3;
    frame64 = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset values
    check("R11 rxValid", {31'd0, rxValid}, 0);
    check("R11 rxLeft", {8'd0, rxLeft}, 0);
    check("R11 rxRight", {8'd0, rxRight}, 0);
    check("R11 sdoOut", {31'd0, sdoOut}, 0);

    // R10: bit clocks with steady word select capture nothing and drive nothing
    begin
      int base, highs;
      doReset(2'd1, 2'd3, 1'b1);
      base = rxCount;
      highs = 0;
      for (int j = 0; j < 40; j++) begin
        @(posedge clk);
        #1 bckIn = 1'b0;
        sdiIn = 1'b1;
        repeat (5) @(posedge clk);
        #1 if (sdoOut !== 1'b0) highs++;
        @(posedge clk);
        #1 bckIn = 1'b1;
        repeat (5) @(posedge clk);
      end
      repeat (10) @(posedge clk);
      check("R10 sdo high count", highs, 0);
      check("R10 strobes", rxCount - base, 0);
    end

    // Table: R1, R3, R4, R5, R6, R7, R9 across framings and lengths
    for (int i = 0; i < 10; i++) begin
      logic [1:0] vf, vw;
      logic vf64;
      logic [23:0] vl, vr, mask;
      int f, nb, s, base, expCnt;
      string req;
      {vf, vw, vf64, vl, vr} = VECS[i];
      f = (vf == 2'd3) ? 1 : int'(vf);
      nb = nbOf(vw, vf64);
      s = vf64 ? 32 : 16;
      mask = ~((24'd1 << (24 - nb)) - 24'd1);
      req = (f == 0) ? "R3/R9 sdo" : (f == 1) ? "R4/R9 sdo" : "R5/R9 sdo";
      doReset(vf, vw, vf64);
      txLeft = vl;
      txRight = vr;
      base = rxCount;
      sendFrame(f, nb, s, vl, vr, 1'b0, 1'b0, 24'd0, req);
      sendFrame(f, nb, s, vl, vr, 1'b1, 1'b0, 24'd0, req);
      sendFrame(f, nb, s, vl, vr, 1'b1, 1'b0, 24'd0, req);
      repeat (20) @(posedge clk);
      #1;
      expCnt = (f == 0 && !vf64) ? 2 : 3;
      check("R1/R6 rxLeft", {8'd0, rxLeft}, {8'd0, vl & mask});
      check("R1/R6 rxRight", {8'd0, rxRight}, {8'd0, vr & mask});
      check("R7 strobe count", rxCount - base, expCnt);
    end

    // R8: a transmit word changed after the left slot begins waits for the next frame
    begin
      logic [23:0] wordA, wordB, wordR;
      wordA = 24'hA1B2C3;
      wordB = 24'h5E6F70;
      wordR = 24'h0F1E2D;
      doReset(2'd1, 2'd3, 1'b1);
      txLeft = wordA;
      txRight = wordR;
      sendFrame(1, 24, 32, wordA, wordR, 1'b0, 1'b0, 24'd0, "R8");
      sendFrame(1, 24, 32, wordA, wordR, 1'b1, 1'b1, wordB, "R8 old word kept");
      sendFrame(1, 24, 32, wordB, wordR, 1'b1, 1'b0, 24'd0, "R8 new word used");
    end

    // R2: serial output changes only after falling edges; quiet bit clock keeps it
    begin
      logic held;
      repeat (20) @(posedge clk);
      #1 held = sdoOut;
      repeat (30) @(posedge clk);
      #1 check("R2 sdo steady without edges", {31'd0, sdoOut}, {31'd0, held});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule